// File: doc/BRIEF.md
# Fractional Oversampling Baud Generator

This block derives the two timing strobes that a serial transmitter and receiver share from a single peripheral clock. A divisor made of an integer mantissa and a fractional part sets the length of one sample period in clock cycles. A mode input selects whether a bit holds 16 or 8 sample periods. The block emits a one-cycle sample strobe at the oversampling rate. On the sample strobe that closes each bit it also emits a bit strobe.

The fractional part is counted in sixteenths when sampling by 16 and in eighths when sampling by 8. In the by-8 mode the top fraction bit is ignored. A fractional accumulator adds the fraction once per sample period. Each period in which the accumulator wraps is lengthened by one clock, so the average period equals the non-integer divisor exactly. The divisor fixes the bit rate as fclk / (8 × (2 − mode) × divisor), with mode 1 meaning by-8.

An enable input stops both strobes and clears all phase state. Raising the enable starts a fresh bit from a known phase. The divisor and mode are meant to be changed while the enable is low.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is active or `en_i` is low, `smp_tick_o` and `bit_tick_o` stay low.
- R2: With `frac_i` = 0, consecutive sample strobes are exactly `mant_i` clock cycles apart.
- R3: When `en_i` rises, the first sample strobe appears on the `mant_i`-th rising clock edge, counting the first edge with `en_i` high as edge 1. The accumulator and bit phase restart from zero.
- R4: In by-16 mode (`os8_i` = 0), every gap between sample strobes is `mant_i` or `mant_i`+1 cycles. Any 16 consecutive gaps sum to exactly 16·`mant_i` + `frac_i`.
- R5: In by-8 mode (`os8_i` = 1), only `frac_i[2:0]` is used, in eighths, and `frac_i[3]` has no effect. Any 16 consecutive gaps sum to 16·`mant_i` + 2·`frac_i[2:0]`.
- R6: In by-16 mode, `bit_tick_o` is high on exactly every 16th sample strobe after enable, and on no other cycle.
- R7: In by-8 mode, `bit_tick_o` is high on exactly every 8th sample strobe after enable, and on no other cycle.
- R8: A mantissa of 0 behaves exactly like a mantissa of 1.
- R9: `bit_tick_o` is never high in a cycle where `smp_tick_o` is low.
- R10: With mantissa 1 and a zero fraction, the sample strobe is high on every cycle. The bit strobe then comes every 16 or every 8 cycles, depending on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Synchronous enable; low clears phase and silences strobes |
| os8_i | input | 1 | Oversampling mode: 0 = 16 samples per bit, 1 = 8 samples per bit |
| mant_i | input | 12 | Integer part of the divisor |
| frac_i | input | 4 | Fractional part of the divisor (sixteenths, or eighths in bits [2:0]) |
| smp_tick_o | output | 1 | One-cycle strobe per sample period |
| bit_tick_o | output | 1 | One-cycle strobe on the last sample strobe of each bit |

## Verification
The bit strobe must land in the same cycle as the sample strobe that closes a bit. With a nonzero fraction, that closing sample period can also be the one lengthened by an accumulator wrap. Vectors with fractions such as 3/16, 15/16 and 5/8 are run for more than two full bits, so wraps fall on bit-closing periods. Every cycle the bench counts sample strobes. It requires the bit strobe exactly when the count reaches a multiple of the bit length, and it judges gap lengths and the 16-gap sum against the exact rational divisor. The degenerate divisor of 1 makes both strobes fire together on consecutive cycles with no idle gap.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned MANT_W    = 12;
  localparam int unsigned FRAC_W    = 4;
  localparam int unsigned OS_WIDE   = 16;
  localparam int unsigned OS_NARROW = 8;
endpackage

// File: rtl/baud_frac_acc.sv
module baud_frac_acc
  import baud_pkg::*;
#(
  parameter int unsigned FW = FRAC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          os8_i,
  input  logic [FW-1:0] frac_i,
  input  logic          hit_i,
  output logic          stretch_o
);
  logic [FW-1:0] acc_q, acc_d;
  logic [FW-1:0] frac_scaled;
  logic [FW:0]   sum;

  // by-8 mode: eighths rescaled to sixteenths so one accumulator serves both modes
  always_comb begin
    frac_scaled = os8_i ? {frac_i[FW-2:0], 1'b0} : frac_i;
    sum         = {1'b0, acc_q} + {1'b0, frac_scaled};
    stretch_o   = sum[FW];
  end

  always_comb begin
    acc_d = acc_q;
    if (!en_i)      acc_d = '0;
    else if (hit_i) acc_d = sum[FW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  AST_ACC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_q == '0); // R3
endmodule

// File: rtl/baud_period_cnt.sv
module baud_period_cnt
  import baud_pkg::*;
#(
  parameter int unsigned MW = MANT_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [MW-1:0] mant_i,
  input  logic          stretch_i,
  output logic          hit_o,
  output logic          tick_o
);
  logic [MW-1:0] cnt_q, cnt_d;
  logic [MW-1:0] mant_eff;
  logic [MW-1:0] target;
  logic          tick_q, tick_d;

  always_comb begin
    mant_eff = (mant_i == '0) ? MW'(1) : mant_i;
    target   = mant_eff - MW'(1) + MW'(stretch_i);
    hit_o    = en_i && (cnt_q == target);
  end

  always_comb begin
    cnt_d  = cnt_q + MW'(1);
    if (!en_i || hit_o) cnt_d = '0;
    tick_d = hit_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_PHASE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> cnt_q == '0); // R3
endmodule

// File: rtl/baud_os_div.sv
module baud_os_div
  import baud_pkg::*;
#(
  parameter int unsigned OS_MAX = OS_WIDE,
  parameter int unsigned OS_MIN = OS_NARROW
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic os8_i,
  input  logic hit_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(OS_MAX);

  logic [CW-1:0] os_q, os_d;
  logic [CW-1:0] last;
  logic          wrap;
  logic          tick_q, tick_d;

  always_comb begin
    last = os8_i ? CW'(OS_MIN - 1) : CW'(OS_MAX - 1);
    wrap = hit_i && (os_q >= last);
  end

  always_comb begin
    os_d = os_q;
    if (!en_i)      os_d = '0;
    else if (wrap)  os_d = '0;
    else if (hit_i) os_d = os_q + CW'(1);
    tick_d = wrap && (os_q == last);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      os_q   <= '0;
      tick_q <= 1'b0;
    end else begin
      os_q   <= os_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_BIT_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_d |=> os_q == '0); // R6
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import baud_pkg::*;
#(
  parameter int unsigned MW     = MANT_W,
  parameter int unsigned FW     = FRAC_W,
  parameter int unsigned OS_MAX = OS_WIDE,
  parameter int unsigned OS_MIN = OS_NARROW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          os8_i,
  input  logic [MW-1:0] mant_i,
  input  logic [FW-1:0] frac_i,
  output logic          smp_tick_o,
  output logic          bit_tick_o
);
  logic rst_meta_q, rst_sync_q;
  logic hit;
  logic stretch;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  baud_frac_acc #(.FW(FW)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .en_i      (en_i),
    .os8_i     (os8_i),
    .frac_i    (frac_i),
    .hit_i     (hit),
    .stretch_o (stretch)
  );

  baud_period_cnt #(.MW(MW)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_q),
    .en_i      (en_i),
    .mant_i    (mant_i),
    .stretch_i (stretch),
    .hit_o     (hit),
    .tick_o    (smp_tick_o)
  );

  baud_os_div #(.OS_MAX(OS_MAX), .OS_MIN(OS_MIN)) u_os (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_q),
    .en_i   (en_i),
    .os8_i  (os8_i),
    .hit_i  (hit),
    .tick_o (bit_tick_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    !en_i |=> !smp_tick_o && !bit_tick_o); // R1
  AST_BIT_WITH_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_sync_q)
    bit_tick_o |-> smp_tick_o); // R9
endmodule

// File: tb/tb_frac_baud_gen.sv
module tb_frac_baud_gen;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 10;
  // {os8, mantissa, fraction}
  localparam logic [16:0] VECS [NVEC] = '{
    {1'b0, 12'd104, 4'd3},
    {1'b0, 12'd5,   4'd0},
    {1'b0, 12'd5,   4'd15},
    {1'b1, 12'd17,  4'd3},
    {1'b1, 12'd4,   4'd15},
    {1'b0, 12'd1,   4'd0},
    {1'b1, 12'd1,   4'd0},
    {1'b0, 12'd0,   4'd0},
    {1'b0, 12'd1,   4'd8},
    {1'b1, 12'd0,   4'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        os8;
  logic [11:0] mant;
  logic [3:0]  frac;
  logic        smp_tick, bit_tick;
  int checks = 0;
  int errors = 0;

  frac_baud_gen dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .os8_i(os8),
    .mant_i(mant), .frac_i(frac), .smp_tick_o(smp_tick), .bit_tick_o(bit_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick1();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_check(input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      tick1();
      if (smp_tick || bit_tick) seen++;
    end
    check("R1 strobes while disabled", seen, 0);
  endtask

  task automatic run_vec(input logic o8, input logic [11:0] m, input logic [3:0] f);
    int meff, fs, nbit, total, cyc, last_cyc, first, nsmp, bad_gap, bad_bit, sum16;
    meff = (m == 0) ? 1 : int'(m);
    fs   = o8 ? 2 * int'(f[2:0]) : int'(f);
    nbit = o8 ? 8 : 16;
    total = 16 * meff + fs;
    en = 1'b0; os8 = o8; mant = m; frac = f;
    idle_check(3);
    en = 1'b1;
    cyc = 0; nsmp = 0; first = -1; last_cyc = 0; bad_gap = 0; bad_bit = 0; sum16 = 0;
    while (nsmp < 33 && cyc < 5000) begin
      tick1();
      cyc++;
      if (bit_tick && !smp_tick) bad_bit++; // R9
      if (smp_tick) begin
        nsmp++;
        if (first < 0) first = cyc;
        else begin
          if ((cyc - last_cyc) != meff && !(fs != 0 && (cyc - last_cyc) == meff + 1))
            bad_gap++;
          if (nsmp <= 17) sum16 += cyc - last_cyc;
        end
        last_cyc = cyc;
        if (bit_tick != ((nsmp % nbit) == 0)) bad_bit++; // R6 / R7
      end
    end
    check("R3 first sample edge", first, meff);
    check(fs == 0 ? "R2 integer gaps" : "R4 gap in {m,m+1}", bad_gap, 0);
    check(o8 ? "R5 16-gap sum (eighths)" : "R4 16-gap sum", sum16, total);
    check(o8 ? "R7 bit every 8 samples" : "R6 bit every 16 samples", bad_bit, 0);
    if (m == 0)              check("R8 mantissa zero as one", first, 1);
    if (meff == 1 && fs == 0) check("R10 tick every cycle", sum16, 16);
    en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; os8 = 1'b0; mant = 12'd3; frac = 4'd0;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        tick1();
        if (smp_tick || bit_tick) seen++;
      end
      check("R1 strobes in reset", seen, 0);
    end
    en = 1'b0;
    tick1();
    rst_n = 1'b1;
    repeat (3) tick1();

    for (int v = 0; v < NVEC; v++)
      run_vec(VECS[v][16], VECS[v][15:4], VECS[v][3:0]);

    // R1: drop enable mid-run, nothing may come out
    os8 = 1'b0; mant = 12'd3; frac = 4'd7; en = 1'b1;
    repeat (10) tick1();
    en = 1'b0;
    tick1();
    idle_check(20);

    // R3: enable mid-period, one-cycle drop, phase must restart
    mant = 12'd9; frac = 4'd0; en = 1'b1;
    repeat (5) tick1();
    en = 1'b0;
    tick1();
    en = 1'b1;
    begin
      int cyc = 0;
      int got = -1;
      while (got < 0 && cyc < 100) begin
        tick1();
        cyc++;
        if (smp_tick) got = cyc;
      end
      check("R3 restart after brief disable", got, 9);
    end

    // R5: frac[3] ignored in by-8 mode, totals equal with and without it
    run_vec(1'b1, 12'd6, 4'b1101);
    run_vec(1'b1, 12'd6, 4'b0101);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule